// File: doc/BRIEF.md
# Touch ADC Scan Sequencer

This block drives an external eight-input, 12-bit touchscreen converter over a four-wire serial link as the bus master. A single start request scans every input selected in the enable mask. The scan runs from the lowest address to the highest. Each selected input gets a burst of 24-bit frames: one command byte goes out, then a 16-bit conversion word comes back. The length of the burst is a number of settling frames followed by a number of oversampled frames. The settling frames are discarded. The remaining 12-bit results are added up and divided by the oversampling ratio, rounded up.

The averaged values are packed into result slots starting at slot 0, in the order the inputs were scanned. A one-cycle done strobe marks the cycle in which every slot and the slot count are valid. Each input has its own settling time, in microseconds, and its own oversampling ratio, both written through a small configuration port. The number of frames to skip is worked out from the settling time and the serial bit period, which is given to the block as a parameter. The serial clock comes from the system clock through a programmable half-period divider.

Top module: `touch_scan_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `busy` and `done` are 0, `res_count` is 0 and every result slot is 0.
- R2: The command byte of each frame is built as follows. Bit 7 is 1. Bits 6:4 hold the input address and bit 3 is 0. Bit 2 is 1 for addresses 0, 2, 6 and 7, and 0 for addresses 1, 3, 4 and 5. Bit 1 is bit 2 AND NOT `ext_ref`. Bit 0 is 1 on every frame of a burst except the last frame, where it is 0.
- R3: A frame is 24 serial clock periods in mode 0: the clock idles low, and data is sampled on the rising edge. MOSI carries the command byte MSB first, followed by 16 zero bits. Each high phase and each low phase of `spi_sclk` lasts `clk_div` system cycles, and a value of 0 counts as 1.
- R4: An input's burst is skip + ratio frames. The skip count is ceil(ceil(settle_us*1000/BIT_NS)/24).
- R5: An input's result is ceil(S/ratio). S is the sum of bits 14:3 of the received words from the frames that follow the skipped ones. Received bits 15 and 2:0 have no effect on the result.
- R6: Selected inputs are scanned in ascending address order. The result for the k-th scanned input is placed in slot k, at bits k*12 and up. `res_count` equals the number of selected inputs, and slots at or above `res_count` read 0.
- R7: After reset, every input has a settling time of 1 µs and a ratio of 1. A ratio written as 0 is stored as 1.
- R8: `spi_cs_n` stays low from before the first serial clock edge of a scan until after its last edge, including the gaps between frames. It is high while the block is idle.
- R9: `done` is high for exactly one cycle. In that cycle all result slots and `res_count` hold the new scan. `busy` is high from the cycle after start until the cycle after `done`.
- R10: While `busy` is high, `start` and configuration writes have no effect. No second scan follows, and the next scan uses the configuration that was in place before.
- R11: A start with an empty enable mask produces `done` one cycle after the scan begins. It produces no serial activity, and `res_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| chan_en | input | NCH | Input selection mask, captured at start |
| ext_ref | input | 1 | An external reference is fitted, captured at start |
| clk_div | input | DIV_W | Serial clock half period in system cycles, captured at start |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ch | input | $clog2(NCH) | Input address the write goes to |
| cfg_settle_us | input | STL_W | Settling time in microseconds |
| cfg_osr | input | OSR_W | Oversampling ratio |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle scan-complete strobe |
| res_count | output | $clog2(NCH+1) | Number of valid result slots |
| results | output | NCH*12 | Packed averaged results, slot 0 in the low bits |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Command data to the converter |
| spi_miso | input | 1 | Conversion data from the converter |

## Verification
The hardest case to reach from the ports is a start pulse and a configuration write that both land in the middle of a burst. Both must be ignored, and the only evidence is what the following scans do. The bench fires both while a scan is running, then checks that no further frames appear and that the next scan's burst lengths and command bytes still match the configuration from before. A bench model of the converter returns random conversion words with random garbage in bits 15 and 2:0. This checks that those bits are masked, while random settling times, ratios, masks and divider values vary the burst shapes and the round-up division.

// File: rtl/tsq_pkg.sv
// Shared constants, state encoding and helper functions for the touch scan
// sequencer. Assumes the 24-bit frame and 12-bit result of the converter.
package tsq_pkg;
    localparam int unsigned FRAME_BITS = 24;
    localparam int unsigned CMD_BITS   = 8;
    localparam int unsigned RES_BITS   = 12;
    localparam int unsigned RES_LSB    = 3;
    localparam int unsigned ADDR_BITS  = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEEK,
        S_FR_GO,
        S_FR_WAIT,
        S_DIV_GO,
        S_DIV_WAIT,
        S_FIN
    } seq_state_t;

    // Command byte: start, address, 12-bit mode, reference and power bits.
    function automatic logic [CMD_BITS-1:0] build_cmd(
        input logic [ADDR_BITS-1:0] addr,
        input logic                 last_frame,
        input logic                 ext_ref
    );
        logic single_ended;
        single_ended = (addr == 3'd0) || (addr == 3'd2) ||
                       (addr == 3'd6) || (addr == 3'd7);
        return {1'b1, addr, 1'b0, single_ended,
                single_ended & ~ext_ref, ~last_frame};
    endfunction

    // Frames to discard for a settling time given the bit period in ns.
    function automatic int unsigned settle_frames(
        input int unsigned settle_us,
        input int unsigned bit_ns
    );
        int unsigned bit_cnt;
        bit_cnt = (settle_us * 1000 + bit_ns - 1) / bit_ns;
        return (bit_cnt + FRAME_BITS - 1) / FRAME_BITS;
    endfunction
endpackage

// File: rtl/tsq_cfg_regs.sv
// Per-input configuration store. Holds the skip count (derived from the
// written settling time) and the oversampling ratio for every input.
// Assumes the caller gates wr_en while a scan is running.
module tsq_cfg_regs
    import tsq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int CH_W   = 3,
    parameter int STL_W  = 8,
    parameter int OSR_W  = 4,
    parameter int SKIP_W = 4,
    parameter int BIT_NS = 1000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CH_W-1:0]       wr_ch,
    input  logic [STL_W-1:0]      wr_settle,
    input  logic [OSR_W-1:0]      wr_osr,
    output logic [NCH*SKIP_W-1:0] skip_flat,
    output logic [NCH*OSR_W-1:0]  osr_flat
);
    localparam logic [SKIP_W-1:0] RST_SKIP = SKIP_W'(settle_frames(1, BIT_NS));

    logic [SKIP_W-1:0] wr_skip;
    logic [OSR_W-1:0]  wr_osr_eff;

    // Convert the written settling time and clamp a zero ratio to one.
    always_comb begin
        wr_skip    = SKIP_W'(settle_frames(int'(wr_settle), BIT_NS));
        wr_osr_eff = (wr_osr == '0) ? OSR_W'(1) : wr_osr;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [SKIP_W-1:0] skip_r;
        logic [OSR_W-1:0]  osr_r;

        // Hold one input's settings; defaults are 1 us settling and ratio 1.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                skip_r <= RST_SKIP;
                osr_r  <= OSR_W'(1);
            end else if (wr_en && wr_ch == CH_W'(g)) begin
                skip_r <= wr_skip;
                osr_r  <= wr_osr_eff;
            end
        end

        assign skip_flat[g*SKIP_W +: SKIP_W] = skip_r;
        assign osr_flat[g*OSR_W +: OSR_W]    = osr_r;

        assert_zero_ratio_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_ch == CH_W'(g) && wr_osr == '0) |=> (osr_r == OSR_W'(1)))
            else $error("zero ratio not stored as one");
    end
endmodule

// File: rtl/tsq_spi_frame.sv
// Shifts one 24-bit frame in serial mode 0: clock idles low, MISO is sampled
// on the rising edge, MOSI changes on the falling edge. Each clock phase
// lasts half_div system cycles (0 treated as 1). Assumes start only when idle.
module tsq_spi_frame
    import tsq_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic [DIV_W-1:0]      half_div,
    input  logic                  miso,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  active,
    output logic                  done,
    output logic [FRAME_BITS-1:0] rx_word
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    logic [DIV_W-1:0]      half_len;
    logic [DIV_W-1:0]      hcnt;
    logic [CNT_W-1:0]      bit_idx;
    logic [FRAME_BITS-1:0] tx_sh;

    // Effective phase length with the zero setting mapped to one cycle.
    always_comb half_len = (half_div == '0) ? DIV_W'(1) : half_div;

    assign mosi = active & tx_sh[FRAME_BITS-1];

    // Phase timer, clock generation and the two shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sclk    <= 1'b0;
            done    <= 1'b0;
            hcnt    <= '0;
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_word <= '0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active  <= 1'b1;
                sclk    <= 1'b0;
                tx_sh   <= tx_word;
                hcnt    <= '0;
                bit_idx <= '0;
            end else if (active) begin
                if (hcnt == DIV_W'(half_len - 1'b1)) begin
                    hcnt <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_word <= {rx_word[FRAME_BITS-2:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bit_idx == CNT_W'(FRAME_BITS - 1)) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b0};
                        end
                    end
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end

    assert_clock_idles_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sclk)
        else $error("serial clock high outside a frame");

    assert_done_after_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!active && !sclk))
        else $error("frame end flagged while still shifting");
endmodule

// File: rtl/tsq_div.sv
// Unsigned restoring divider, one quotient bit per cycle, NUM_W cycles per
// division. Assumes den is non-zero and stable while busy.
module tsq_div #(
    parameter int NUM_W = 16,
    parameter int DEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W:0]   rem;
    logic [DEN_W:0]   trial;
    logic             fits;
    logic [CNT_W-1:0] cnt;

    // Shift in the next dividend bit and test it against the divisor.
    always_comb begin
        trial = {rem[DEN_W-1:0], quot[NUM_W-1]};
        fits  = (trial >= {1'b0, den});
    end

    // Iterate the restoring steps and flag completion for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            quot <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                quot <= num;
                rem  <= '0;
                cnt  <= CNT_W'(NUM_W);
                busy <= 1'b1;
            end else if (busy) begin
                rem  <= fits ? (trial - {1'b0, den}) : trial;
                quot <= {quot[NUM_W-2:0], fits};
                cnt  <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assert_rem_below_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem < {1'b0, den}))
        else $error("partial remainder out of range");
endmodule

// File: rtl/touch_scan_seq.sv
// Scan sequencer for an eight-input touchscreen converter. On start it walks
// the enable mask from low to high address. For each input it issues a burst
// of frames, drops the settling frames, and averages the rest with round-up.
// The result goes into the next packed slot. Assumes NCH <= 8 (3-bit address)
// and that BIT_NS matches the serial bit period produced by clk_div.
module touch_scan_seq
    import tsq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int STL_W  = 8,
    parameter int OSR_W  = 4,
    parameter int DIV_W  = 4,
    parameter int BIT_NS = 1000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NCH-1:0]             chan_en,
    input  logic                       ext_ref,
    input  logic [DIV_W-1:0]           clk_div,
    input  logic                       cfg_wr,
    input  logic [$clog2(NCH)-1:0]     cfg_ch,
    input  logic [STL_W-1:0]           cfg_settle_us,
    input  logic [OSR_W-1:0]           cfg_osr,
    output logic                       busy,
    output logic                       done,
    output logic [$clog2(NCH+1)-1:0]   res_count,
    output logic [NCH*RES_BITS-1:0]    results,
    output logic                       spi_cs_n,
    output logic                       spi_sclk,
    output logic                       spi_mosi,
    input  logic                       spi_miso
);
    localparam int CH_W     = $clog2(NCH);
    localparam int CNT_W    = $clog2(NCH + 1);
    localparam int MAX_SKIP = int'(settle_frames((2 ** STL_W) - 1, BIT_NS));
    localparam int SKIP_W   = (MAX_SKIP > 0) ? $clog2(MAX_SKIP + 1) : 1;
    localparam int BURST_W  = ((SKIP_W > OSR_W) ? SKIP_W : OSR_W) + 1;
    localparam int SUM_W    = RES_BITS + OSR_W;

    seq_state_t            st;
    logic [NCH-1:0]        pend;
    logic [CH_W-1:0]       cur_ch;
    logic [CH_W-1:0]       low_idx;
    logic [CNT_W-1:0]      slot;
    logic [BURST_W-1:0]    fidx;
    logic [BURST_W-1:0]    burst_len;
    logic [SKIP_W-1:0]     cur_skip;
    logic [OSR_W-1:0]      cur_osr;
    logic [SUM_W-1:0]      sum;
    logic                  ext_q;
    logic [DIV_W-1:0]      div_q;
    logic                  cs_n_q;
    logic [NCH*RES_BITS-1:0] res_q;

    logic [NCH*SKIP_W-1:0] skip_flat;
    logic [NCH*OSR_W-1:0]  osr_flat;
    logic [SKIP_W-1:0]     low_skip;
    logic [OSR_W-1:0]      low_osr;
    logic                  last_frame;
    logic [CMD_BITS-1:0]   cmd;
    logic                  fr_start;
    logic                  fr_done;
    logic                  fr_active;
    logic [FRAME_BITS-1:0] rx_word;
    logic [RES_BITS-1:0]   rx_res;
    logic                  dv_start;
    logic                  dv_busy;
    logic                  dv_done;
    logic [SUM_W-1:0]      dv_num;
    logic [SUM_W-1:0]      dv_quot;

    tsq_cfg_regs #(
        .NCH    (NCH),
        .CH_W   (CH_W),
        .STL_W  (STL_W),
        .OSR_W  (OSR_W),
        .SKIP_W (SKIP_W),
        .BIT_NS (BIT_NS)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr && (st == S_IDLE)),
        .wr_ch     (cfg_ch),
        .wr_settle (cfg_settle_us),
        .wr_osr    (cfg_osr),
        .skip_flat (skip_flat),
        .osr_flat  (osr_flat)
    );

    tsq_spi_frame #(
        .DIV_W (DIV_W)
    ) i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (fr_start),
        .tx_word  ({cmd, {(FRAME_BITS - CMD_BITS){1'b0}}}),
        .half_div (div_q),
        .miso     (spi_miso),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .active   (fr_active),
        .done     (fr_done),
        .rx_word  (rx_word)
    );

    tsq_div #(
        .NUM_W (SUM_W),
        .DEN_W (OSR_W)
    ) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dv_start),
        .num   (dv_num),
        .den   (cur_osr),
        .busy  (dv_busy),
        .done  (dv_done),
        .quot  (dv_quot)
    );

    // Lowest pending input address, picked by a priority scan.
    always_comb begin
        low_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) low_idx = CH_W'(i);
        end
        low_skip = skip_flat[low_idx*SKIP_W +: SKIP_W];
        low_osr  = osr_flat[low_idx*OSR_W +: OSR_W];
    end

    // Frame command, received sample and divider operand for the burst.
    always_comb begin
        last_frame = (fidx == BURST_W'(burst_len - 1'b1));
        cmd        = build_cmd(ADDR_BITS'(cur_ch), last_frame, ext_q);
        rx_res     = rx_word[RES_LSB +: RES_BITS];
        fr_start   = (st == S_FR_GO);
        dv_start   = (st == S_DIV_GO);
        dv_num     = sum + SUM_W'(cur_osr) - SUM_W'(1);
    end

    // Scan control: input selection, frame bursts, accumulation, results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            pend      <= '0;
            cur_ch    <= '0;
            slot      <= '0;
            fidx      <= '0;
            burst_len <= '0;
            cur_skip  <= '0;
            cur_osr   <= OSR_W'(1);
            sum       <= '0;
            ext_q     <= 1'b0;
            div_q     <= '0;
            cs_n_q    <= 1'b1;
            res_q     <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (start) begin
                        pend  <= chan_en;
                        ext_q <= ext_ref;
                        div_q <= clk_div;
                        slot  <= '0;
                        res_q <= '0;
                        st    <= S_SEEK;
                    end
                end
                S_SEEK: begin
                    if (pend != '0) begin
                        cur_ch        <= low_idx;
                        pend[low_idx] <= 1'b0;
                        cur_skip      <= low_skip;
                        cur_osr       <= low_osr;
                        burst_len     <= BURST_W'(low_skip) + BURST_W'(low_osr);
                        fidx          <= '0;
                        sum           <= '0;
                        cs_n_q        <= 1'b0;
                        st            <= S_FR_GO;
                    end else begin
                        st <= S_FIN;
                    end
                end
                S_FR_GO: st <= S_FR_WAIT;
                S_FR_WAIT: begin
                    if (fr_done) begin
                        if (fidx >= BURST_W'(cur_skip)) sum <= sum + SUM_W'(rx_res);
                        if (last_frame) begin
                            st <= S_DIV_GO;
                        end else begin
                            fidx <= fidx + 1'b1;
                            st   <= S_FR_GO;
                        end
                    end
                end
                S_DIV_GO: st <= S_DIV_WAIT;
                S_DIV_WAIT: begin
                    if (dv_done) begin
                        res_q[slot*RES_BITS +: RES_BITS] <= dv_quot[RES_BITS-1:0];
                        slot <= slot + 1'b1;
                        st   <= S_SEEK;
                    end
                end
                S_FIN: begin
                    cs_n_q <= 1'b1;
                    st     <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy      = (st != S_IDLE);
    assign done      = (st == S_FIN);
    assign res_count = slot;
    assign results   = res_q;
    assign spi_cs_n  = cs_n_q;

    assert_done_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done wider than one cycle");

    assert_select_covers_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n)
        else $error("serial clock toggles with chip select high");

    assert_idle_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> spi_cs_n)
        else $error("chip select low while idle");

    assert_frame_index_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FR_WAIT) |-> (fidx < burst_len))
        else $error("frame index past burst length");

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fr_start |-> (!fr_active && !dv_busy))
        else $error("frame started while another unit busy");
endmodule

// File: tb/test_touch_scan_seq.sv
`timescale 1ns/1ps
module test_touch_scan_seq;
    localparam int NCH    = 8;
    localparam int BIT_NS = 1000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  chan_en;
    logic        ext_ref;
    logic [3:0]  clk_div;
    logic        cfg_wr;
    logic [2:0]  cfg_ch;
    logic [7:0]  cfg_settle_us;
    logic [3:0]  cfg_osr;
    logic        busy, done;
    logic [3:0]  res_count;
    logic [95:0] results;
    logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;

    int n_chk = 0;
    int n_fail = 0;
    int m_skip [NCH];
    int m_osr  [NCH];

    logic [7:0] fr_cmd [512];
    int         fr_val [512];
    int         nfr = 0;
    int         bitpos = 0;
    logic [7:0] sl_cmd = '0;
    logic [15:0] sl_word = '0;
    int         sl_val = 0;
    int         hi_cnt = 0;
    int         hi_bad = 0;
    int         cs_viol = 0;
    int         exp_hi = 1;

    always #2.5 clk = ~clk;

    touch_scan_seq #(.NCH(NCH), .BIT_NS(BIT_NS)) i_touch_scan_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_en(chan_en),
        .ext_ref(ext_ref), .clk_div(clk_div), .cfg_wr(cfg_wr), .cfg_ch(cfg_ch),
        .cfg_settle_us(cfg_settle_us), .cfg_osr(cfg_osr), .busy(busy),
        .done(done), .res_count(res_count), .results(results),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int skip_of(input int settle);
        int bits;
        bits = (settle * 1000 + BIT_NS - 1) / BIT_NS;
        return (bits + 23) / 24;
    endfunction

    function automatic logic [7:0] exp_cmd(input int ch, input bit last, input bit ext);
        bit se;
        se = (ch == 0) || (ch == 2) || (ch == 6) || (ch == 7);
        return {1'b1, 3'(ch), 1'b0, se, se && !ext, !last};
    endfunction

    // Converter model: collects command bytes, answers with random words.
    initial begin
        spi_miso = 1'b0;
        forever begin
            @(posedge spi_sclk or posedge spi_cs_n);
            if (spi_cs_n) begin
                bitpos = 0;
            end else begin
                if (bitpos < 8) sl_cmd = {sl_cmd[6:0], spi_mosi};
                if (bitpos == 7) begin
                    sl_val = int'($urandom % 4096);
                    sl_word = {1'($urandom), 12'(sl_val), 3'($urandom)};
                    if (nfr < 512) begin
                        fr_cmd[nfr] = sl_cmd;
                        fr_val[nfr] = sl_val;
                    end
                end
                @(negedge spi_sclk);
                if (bitpos >= 7 && bitpos < 23) spi_miso = sl_word[22 - bitpos];
                else spi_miso = 1'($urandom);
                if (bitpos == 23) begin
                    bitpos = 0;
                    nfr++;
                end else begin
                    bitpos++;
                end
            end
        end
    end

    // Serial clock phase and chip-select monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (spi_sclk) hi_cnt++;
            else if (hi_cnt != 0) begin
                if (hi_cnt != exp_hi) hi_bad++;
                hi_cnt = 0;
            end
            if (spi_sclk && spi_cs_n) cs_viol++;
        end
    end

    // Watchdog: a hung run is reported as one extra failed check.
    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
        $finish;
    end

    task automatic cfg_write(input int ch, input int settle, input int osr);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_ch = 3'(ch); cfg_settle_us = 8'(settle); cfg_osr = 4'(osr);
        @(negedge clk);
        cfg_wr = 1'b0;
        m_skip[ch] = skip_of(settle);
        m_osr[ch]  = (osr == 0) ? 1 : osr;
    endtask

    task automatic run_scan(input logic [7:0] mask, input bit ext, input int div, input bit meddle);
        int base, hb0, cv0, guard, idx, burst, sum, ex, slot, total, act, after;
        base = nfr; hb0 = hi_bad; cv0 = cs_viol;
        exp_hi = (div == 0) ? 1 : div;
        @(negedge clk);
        chan_en = mask; ext_ref = ext; clk_div = 4'(div); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
        guard = 0;
        while (done !== 1'b1 && guard < 60000) begin
            @(negedge clk);
            guard++;
            if (meddle && guard == 30) begin
                start = 1'b1; cfg_wr = 1'b1; cfg_ch = 3'd0; cfg_osr = 4'd9; cfg_settle_us = 8'd0;
            end
            if (meddle && guard == 31) begin
                start = 1'b0; cfg_wr = 1'b0;
            end
        end
        chk(done == 1'b1, "R9 done reached", int'(done), 1);
        if (mask == 0) chk(guard == 1, "R11 empty scan latency", guard, 1);
        idx = base; slot = 0; total = 0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (mask[ch]) begin
                burst = m_skip[ch] + m_osr[ch];
                sum = 0;
                for (int k = 0; k < burst; k++) begin
                    chk(fr_cmd[idx + k] == exp_cmd(ch, k == burst - 1, ext),
                        "R2 command byte", int'(fr_cmd[idx + k]), int'(exp_cmd(ch, k == burst - 1, ext)));
                    if (k >= m_skip[ch]) sum += fr_val[idx + k];
                end
                ex = (sum + m_osr[ch] - 1) / m_osr[ch];
                act = int'(results[slot*12 +: 12]);
                chk(act == ex, "R5 R6 averaged result", act, ex);
                idx += burst; total += burst; slot++;
            end
        end
        for (int s = slot; s < NCH; s++)
            chk(results[s*12 +: 12] == 12'd0, "R6 unused slot", int'(results[s*12 +: 12]), 0);
        chk(int'(res_count) == slot, "R6 slot count", int'(res_count), slot);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
        chk(busy == 1'b0, "R9 busy falls", int'(busy), 0);
        repeat (60) @(negedge clk);
        after = nfr - base;
        chk(after == total, "R4 frames per scan", after, total);
        chk(busy == 1'b0 && spi_cs_n == 1'b1, "R10 R8 idle after scan", int'(busy), 0);
        chk(hi_bad == hb0, "R3 clock phase length", hi_bad - hb0, 0);
        chk(cs_viol == cv0, "R8 select during clock", cs_viol - cv0, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; start = 1'b0; chan_en = '0; ext_ref = 1'b0; clk_div = 4'd2;
        cfg_wr = 1'b0; cfg_ch = '0; cfg_settle_us = '0; cfg_osr = '0;
        for (int c = 0; c < NCH; c++) begin
            m_skip[c] = skip_of(1);
            m_osr[c]  = 1;
        end
        repeat (5) @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R1 serial pins", int'({spi_cs_n, spi_sclk}), 2);
        chk(busy == 1'b0 && done == 1'b0, "R1 status", int'({busy, done}), 0);
        chk(results == '0 && res_count == '0, "R1 results", int'(res_count), 0);
        rst_n = 1'b1;

        // R7 defaults: every input bursts skip 1 + ratio 1.
        run_scan(8'hFF, 1'b0, 2, 1'b0);

        // R4 R2 directed shapes, including a single-frame burst and zero ratio.
        cfg_write(1, 0, 1);
        cfg_write(3, 50, 4);
        cfg_write(6, 200, 0);
        cfg_write(7, 24, 15);
        run_scan(8'b1100_1010, 1'b1, 1, 1'b0);

        // R11 empty mask.
        run_scan(8'h00, 1'b0, 1, 1'b0);

        // R10 start and config write during a scan, divider 0 acting as 1.
        run_scan(8'b0000_1001, 1'b0, 0, 1'b1);
        run_scan(8'b0000_0001, 1'b0, 3, 1'b0);

        // Random configurations, masks and divider settings.
        for (int it = 0; it < 6; it++) begin
            for (int c = 0; c < NCH; c++)
                cfg_write(c, int'($urandom % 81), int'($urandom % 7));
            run_scan(8'($urandom), 1'($urandom), 1 + int'($urandom % 3), 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule